// File: doc/BRIEF.md
# Branch Special-Register Unit

This block keeps the three 32-bit special-purpose registers that a branch unit works with. The first is a link register, which holds a return address. The second is a count register, which serves as a loop counter and also as a branch destination. The third is a user scratch register that software may use freely. Software reaches all three through a move-to/move-from port, and a 10-bit register number selects the register. A read returns its data one cycle after the request. A read of a number that maps to no register returns zero and raises an illegal-access flag.

On the branch side, the block takes three simple strobes. A decrement strobe steps the count register down by one, and it wraps from zero to all ones. A zero flag is computed combinationally from the value the count register will hold after that decrement, so a branch can test it in the same cycle. A link strobe loads the link register with the supplied instruction address plus four. Two target outputs present the link and count registers as word-aligned branch addresses. The two low bits of both registers still keep whatever value software wrote into them.

Top module: `branch_spr_unit`

## Requirements
- R1: Register number 8 selects the link register, 9 selects the count register and 256 selects the user register. A write stores all 32 bits on the clock edge. A read returns the contents held before that edge on `spr_rd_data` in the following cycle, with `spr_rd_valid` high for that one cycle.
- R2: Bits 1:0 of the link and count registers keep any written value, and a port read returns those bits unchanged.
- R3: `lr_target` and `ctr_target` equal the link and count registers with bits 1:0 forced to zero.
- R4: With `ctr_dec` high and no port write to number 9, the count register becomes its value minus one on the clock edge. From zero it becomes 0xFFFF_FFFF.
- R5: `ctr_zero` is high in the same cycle exactly when the count register minus one equals zero, which means the count register holds 1.
- R6: With `link_wr` high and no port write to number 8, the link register loads `instr_addr` + 4 (modulo 2^32) on the clock edge.
- R7: A port write to the count register overrides a simultaneous decrement, and a port write to the link register overrides a simultaneous link capture. A port write to another number does not block either strobe.
- R8: A read of any number other than 8, 9 or 256 returns 0 and raises `spr_illegal` for exactly the one cycle in which its data is presented. A write to such a number changes no register.
- R9: The user register's value has no effect on `lr_target`, `ctr_target` or `ctr_zero`.
- R10: While `rst` is high at a clock edge, all three registers clear to zero, and so do `spr_rd_valid` and `spr_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_num | input | 10 | Special-register number for the port access |
| spr_wr_en | input | 1 | Port write strobe |
| spr_wr_data | input | 32 | Port write data |
| spr_rd_en | input | 1 | Port read strobe |
| spr_rd_data | output | 32 | Registered read data |
| spr_rd_valid | output | 1 | Read data valid, one cycle after the request |
| spr_illegal | output | 1 | Read of an unmapped number, aligned with its data |
| ctr_dec | input | 1 | Decrement the count register |
| ctr_zero | output | 1 | Count minus one is zero (combinational) |
| link_wr | input | 1 | Capture a return address into the link register |
| instr_addr | input | 32 | Address of the current branch instruction |
| lr_target | output | 32 | Word-aligned target taken from the link register |
| ctr_target | output | 32 | Word-aligned target taken from the count register |

## Verification
The properties assume that `spr_num` and the strobes are known and stable around each rising edge. They also assume that a decrement or link capture is judged against a port write only when the register number equals 8 or 9 exactly. To stay within this, the stimulus changes every input only on the falling edge. It also crosses each strobe with writes to the same register and to other numbers, so that the override rule is exercised in both directions. The wrap cases use count values 0 and 1 and link addresses near the top of the address space, where the adder and the decrementer overflow.

// File: rtl/bspr_pkg.sv
package bspr_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_W      = 10;
  localparam int unsigned ALIGN_BITS = 2;
  localparam int unsigned RET_OFFSET = 4;
  localparam int unsigned LR_NUM     = 8;
  localparam int unsigned CTR_NUM    = 9;
  localparam int unsigned USR_NUM    = 256;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LR   = 2'd1,
    SEL_CTR  = 2'd2,
    SEL_USR  = 2'd3
  } spr_sel_e;
endpackage

// File: rtl/bspr_decode.sv
module bspr_decode
  import bspr_pkg::*;
#(
  parameter int unsigned NW    = NUM_W,
  parameter int unsigned N_LR  = LR_NUM,
  parameter int unsigned N_CTR = CTR_NUM,
  parameter int unsigned N_USR = USR_NUM
) (
  input  logic [NW-1:0] num,
  output spr_sel_e      sel
);
  always_comb begin
    if (num == NW'(N_LR))       sel = SEL_LR;
    else if (num == NW'(N_CTR)) sel = SEL_CTR;
    else if (num == NW'(N_USR)) sel = SEL_USR;
    else                        sel = SEL_NONE;
  end
endmodule

// File: rtl/bspr_count.sv
module bspr_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         port_wr,
  input  logic [W-1:0] port_data,
  input  logic         dec,
  output logic [W-1:0] count_q,
  output logic         zero_next
);
  logic [W-1:0] dec_val;

  // modulo subtraction gives the wrap from zero to all ones
  assign dec_val   = count_q - W'(1);
  assign zero_next = (dec_val == '0);

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (port_wr) count_q <= port_data;
    else if (dec)     count_q <= dec_val;
  end
endmodule

// File: rtl/bspr_link.sv
module bspr_link #(
  parameter int unsigned W   = 32,
  parameter int unsigned OFS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         port_wr,
  input  logic [W-1:0] port_data,
  input  logic         capture,
  input  logic [W-1:0] pc,
  output logic [W-1:0] link_q
);
  logic [W-1:0] ret_addr;

  assign ret_addr = pc + W'(OFS);

  always_ff @(posedge clk) begin
    if (rst)          link_q <= '0;
    else if (port_wr) link_q <= port_data;
    else if (capture) link_q <= ret_addr;
  end
endmodule

// File: rtl/bspr_read.sv
module bspr_read
  import bspr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  spr_sel_e     sel,
  input  logic [W-1:0] lr_q,
  input  logic [W-1:0] ctr_q,
  input  logic [W-1:0] usr_q,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         illegal
);
  logic [W-1:0] mux_val;

  always_comb begin
    unique case (sel)
      SEL_LR:  mux_val = lr_q;
      SEL_CTR: mux_val = ctr_q;
      SEL_USR: mux_val = usr_q;
      default: mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      illegal  <= rd_en && (sel == SEL_NONE);
      rd_data  <= rd_en ? mux_val : '0;
    end
  end
endmodule

// File: rtl/branch_spr_unit.sv
module branch_spr_unit
  import bspr_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned NW    = NUM_W,
  parameter int unsigned AB    = ALIGN_BITS,
  parameter int unsigned OFS   = RET_OFFSET,
  parameter int unsigned N_LR  = LR_NUM,
  parameter int unsigned N_CTR = CTR_NUM,
  parameter int unsigned N_USR = USR_NUM
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] spr_num,
  input  logic          spr_wr_en,
  input  logic [W-1:0]  spr_wr_data,
  input  logic          spr_rd_en,
  output logic [W-1:0]  spr_rd_data,
  output logic          spr_rd_valid,
  output logic          spr_illegal,
  input  logic          ctr_dec,
  output logic          ctr_zero,
  input  logic          link_wr,
  input  logic [W-1:0]  instr_addr,
  output logic [W-1:0]  lr_target,
  output logic [W-1:0]  ctr_target
);
  localparam int unsigned  N_TGT      = 2;
  localparam logic [W-1:0] ALIGN_MASK = ~W'((1 << AB) - 1);

  spr_sel_e     sel;
  logic [W-1:0] lr_q, ctr_q, usr_q;
  logic         wr_lr, wr_ctr, wr_usr;
  logic [N_TGT-1:0][W-1:0] tgt_src, tgt_out;

  bspr_decode #(.NW(NW), .N_LR(N_LR), .N_CTR(N_CTR), .N_USR(N_USR)) u_dec (
    .num (spr_num),
    .sel (sel)
  );

  assign wr_lr  = spr_wr_en && (sel == SEL_LR);
  assign wr_ctr = spr_wr_en && (sel == SEL_CTR);
  assign wr_usr = spr_wr_en && (sel == SEL_USR);

  bspr_link #(.W(W), .OFS(OFS)) u_link (
    .clk       (clk),
    .rst       (rst),
    .port_wr   (wr_lr),
    .port_data (spr_wr_data),
    .capture   (link_wr),
    .pc        (instr_addr),
    .link_q    (lr_q)
  );

  bspr_count #(.W(W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .port_wr   (wr_ctr),
    .port_data (spr_wr_data),
    .dec       (ctr_dec),
    .count_q   (ctr_q),
    .zero_next (ctr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)         usr_q <= '0;
    else if (wr_usr) usr_q <= spr_wr_data;
  end

  bspr_read #(.W(W)) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (spr_rd_en),
    .sel      (sel),
    .lr_q     (lr_q),
    .ctr_q    (ctr_q),
    .usr_q    (usr_q),
    .rd_data  (spr_rd_data),
    .rd_valid (spr_rd_valid),
    .illegal  (spr_illegal)
  );

  assign tgt_src[0] = lr_q;
  assign tgt_src[1] = ctr_q;

  for (genvar g = 0; g < N_TGT; g++) begin : g_align
    assign tgt_out[g] = tgt_src[g] & ALIGN_MASK;
  end

  assign lr_target  = tgt_out[0];
  assign ctr_target = tgt_out[1];
endmodule

// File: rtl/bspr_checker.sv
module bspr_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned NW    = 10,
  parameter int unsigned OFS   = 4,
  parameter int unsigned N_LR  = 8,
  parameter int unsigned N_CTR = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] spr_num,
  input logic          spr_wr_en,
  input logic [W-1:0]  spr_wr_data,
  input logic          spr_rd_en,
  input logic [W-1:0]  spr_rd_data,
  input logic          spr_illegal,
  input logic          ctr_dec,
  input logic          ctr_zero,
  input logic          link_wr,
  input logic [W-1:0]  instr_addr,
  input logic [W-1:0]  lr_q,
  input logic [W-1:0]  ctr_q
);
  logic pw_ctr, pw_lr;
  assign pw_ctr = spr_wr_en && (spr_num == NW'(N_CTR));
  assign pw_lr  = spr_wr_en && (spr_num == NW'(N_LR));

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (ctr_dec && !pw_ctr) |=> (ctr_q == $past(ctr_q) - W'(1)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (ctr_dec && !pw_ctr && ctr_q == '0) |=> (ctr_q == '1));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ctr_zero && ctr_dec && !pw_ctr) |=> (ctr_q == '0));

  p_link_r6: assert property (@(posedge clk) disable iff (rst)
    (link_wr && !pw_lr) |=> (lr_q == $past(instr_addr) + W'(OFS)));

  p_ctr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    pw_ctr |=> (ctr_q == $past(spr_wr_data)));

  p_lr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    pw_lr |=> (lr_q == $past(spr_wr_data)));

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    spr_illegal |-> (spr_rd_data == '0));

  p_illegal_src_r8: assert property (@(posedge clk) disable iff (rst)
    spr_illegal |-> $past(spr_rd_en));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (lr_q == '0 && ctr_q == '0 && !spr_illegal));
endmodule

bind branch_spr_unit bspr_checker #(
  .W(W), .NW(NW), .OFS(OFS), .N_LR(N_LR), .N_CTR(N_CTR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .spr_num     (spr_num),
  .spr_wr_en   (spr_wr_en),
  .spr_wr_data (spr_wr_data),
  .spr_rd_en   (spr_rd_en),
  .spr_rd_data (spr_rd_data),
  .spr_illegal (spr_illegal),
  .ctr_dec     (ctr_dec),
  .ctr_zero    (ctr_zero),
  .link_wr     (link_wr),
  .instr_addr  (instr_addr),
  .lr_q        (lr_q),
  .ctr_q       (ctr_q)
);

// File: tb/branch_spr_unit_tb.sv
module branch_spr_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  spr_num = '0;
  logic        spr_wr_en = 1'b0;
  logic [31:0] spr_wr_data = '0;
  logic        spr_rd_en = 1'b0;
  logic [31:0] spr_rd_data;
  logic        spr_rd_valid;
  logic        spr_illegal;
  logic        ctr_dec = 1'b0;
  logic        ctr_zero;
  logic        link_wr = 1'b0;
  logic [31:0] instr_addr = '0;
  logic [31:0] lr_target;
  logic [31:0] ctr_target;

  always #(CLK_P/2) clk = ~clk;

  branch_spr_unit u_dut (
    .clk(clk), .rst(rst), .spr_num(spr_num), .spr_wr_en(spr_wr_en),
    .spr_wr_data(spr_wr_data), .spr_rd_en(spr_rd_en), .spr_rd_data(spr_rd_data),
    .spr_rd_valid(spr_rd_valid), .spr_illegal(spr_illegal), .ctr_dec(ctr_dec),
    .ctr_zero(ctr_zero), .link_wr(link_wr), .instr_addr(instr_addr),
    .lr_target(lr_target), .ctr_target(ctr_target)
  );

  typedef struct {
    logic [31:0] data;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_lr = '0, m_ctr = '0, m_usr = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (!rst && spr_rd_valid) begin
      if (sb.size() == 0) begin
        check("R1 unexpected read", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " read data"}, spr_rd_data, e.data);
        check({e.tag, " illegal flag"}, {31'd0, spr_illegal}, {31'd0, e.ill});
      end
    end else if (!rst && spr_illegal) begin
      check("R8 illegal without data", 32'd1, 32'd0);
    end
  end

  // driver: one cycle of stimulus, model update and target checks
  task automatic step(input logic wr, input logic rd, input logic [9:0] num,
                      input logic [31:0] wd, input logic dec, input logic lnk,
                      input logic [31:0] ia, input string tag);
    exp_t e;
    @(negedge clk);
    spr_wr_en = wr; spr_rd_en = rd; spr_num = num; spr_wr_data = wd;
    ctr_dec = dec; link_wr = lnk; instr_addr = ia;
    if (rd) begin
      e.tag = tag;
      e.ill = 1'b0;
      case (num)
        10'd8:   e.data = m_lr;
        10'd9:   e.data = m_ctr;
        10'd256: e.data = m_usr;
        default: begin e.data = '0; e.ill = 1'b1; end
      endcase
      sb.push_back(e);
    end
    #1;
    check("R5 zero flag", {31'd0, ctr_zero}, {31'd0, (m_ctr - 32'd1) == 32'd0});
    @(posedge clk);
    if (wr && num == 10'd9) m_ctr = wd;
    else if (dec)           m_ctr = m_ctr - 32'd1;
    if (wr && num == 10'd8) m_lr = wd;
    else if (lnk)           m_lr = ia + 32'd4;
    if (wr && num == 10'd256) m_usr = wd;
    #1;
    spr_wr_en = 1'b0; spr_rd_en = 1'b0; ctr_dec = 1'b0; link_wr = 1'b0;
    check({tag, " R3 lr_target"}, lr_target, m_lr & 32'hFFFF_FFFC);
    check({tag, " R3 ctr_target"}, ctr_target, m_ctr & 32'hFFFF_FFFC);
  endtask

  task automatic wr(input logic [9:0] n, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, n, d, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic rd(input logic [9:0] n, input string tag);
    step(1'b0, 1'b1, n, 32'd0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R10 rd_valid in reset", {31'd0, spr_rd_valid}, 32'd0);
    check("R10 lr_target in reset", lr_target, 32'd0);
    check("R10 ctr_target in reset", ctr_target, 32'd0);
    sb.delete();
    m_lr = '0; m_ctr = '0; m_usr = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: every register reads zero after reset
    rd(10'd8, "R10 lr"); rd(10'd9, "R10 ctr"); rd(10'd256, "R10 usr");

    // R1, R2: full-width writes and read-back with odd low bits
    wr(10'd8, 32'h1234_5677, "R1 lr wr");
    wr(10'd9, 32'hCAFE_F00D, "R2 ctr wr");
    wr(10'd256, 32'hA5A5_5A5B, "R1 usr wr");
    rd(10'd8, "R2 lr read");
    rd(10'd9, "R2 ctr read");
    rd(10'd256, "R1 usr read");
    // R1: read in the same cycle as a write returns the old value
    step(1'b1, 1'b1, 10'd8, 32'h0000_0003, 1'b0, 1'b0, 32'd0, "R1 old value");
    rd(10'd8, "R2 low bits only");

    // R4: ordinary decrement and wrap from zero
    wr(10'd9, 32'd3, "R4 load");
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b1, 1'b0, 32'd0, "R4 dec");
    rd(10'd9, "R4 after dec");
    // R5: count is 2 then 1, flag high only at 1
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b1, 1'b0, 32'd0, "R5 dec to one");
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b1, 1'b0, 32'd0, "R5 dec to zero");
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b1, 1'b0, 32'd0, "R4 wrap");
    rd(10'd9, "R4 wrapped value");

    // R6: link capture, including wrap of the adder
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b0, 1'b1, 32'h0000_1000, "R6 capture");
    rd(10'd8, "R6 link value");
    step(1'b0, 1'b0, 10'd0, 32'd0, 1'b0, 1'b1, 32'hFFFF_FFFE, "R6 capture wrap");
    rd(10'd8, "R6 link wrap value");

    // R7: port write overrides strobes on the same register only
    step(1'b1, 1'b0, 10'd9, 32'h0000_0050, 1'b1, 1'b0, 32'd0, "R7 ctr write vs dec");
    rd(10'd9, "R7 ctr wins");
    step(1'b1, 1'b0, 10'd8, 32'h0000_0A01, 1'b0, 1'b1, 32'h0000_2000, "R7 lr write vs link");
    rd(10'd8, "R7 lr wins");
    step(1'b1, 1'b0, 10'd8, 32'h0000_0B00, 1'b1, 1'b0, 32'd0, "R7 lr write with dec");
    rd(10'd9, "R7 dec still applied");
    step(1'b1, 1'b0, 10'd9, 32'h0000_0010, 1'b0, 1'b1, 32'h0000_3000, "R7 ctr write with link");
    rd(10'd8, "R7 link still applied");

    // R8: unmapped reads and ignored writes
    rd(10'd10, "R8 unmapped 10");
    rd(10'h3FF, "R8 unmapped 3FF");
    wr(10'd0, 32'hDEAD_BEEF, "R8 write ignored");
    wr(10'd264, 32'hDEAD_BEEF, "R8 write ignored");
    rd(10'd8, "R8 lr untouched");
    rd(10'd9, "R8 ctr untouched");
    rd(10'd256, "R8 usr untouched");

    // R9: user register has no side effects
    wr(10'd9, 32'd1, "R9 ctr one");
    wr(10'd256, 32'hFFFF_FFFF, "R9 usr ones");
    wr(10'd256, 32'h0000_0000, "R9 usr zero");
    rd(10'd9, "R9 ctr intact");

    // R10: reset in mid-run clears everything
    wr(10'd256, 32'h7777_7777, "R10 preload");
    do_reset();
    rd(10'd8, "R10 lr cleared");
    rd(10'd9, "R10 ctr cleared");
    rd(10'd256, "R10 usr cleared");

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", sb.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule